// File: doc/BRIEF.md
# Paged receive ring buffer writer

This block sits between a receive byte stream and a byte-wide packet buffer RAM. The RAM is seen as an array of 256-byte pages, and a contiguous range of them, from a first page up to (not including) a limit page, forms a circular receive ring. Each incoming frame is written into the ring page by page. Its first data byte lands at offset 4 of the current page. When the frame ends, a 4-byte header is filled in at offsets 0 to 3 of the frame's first page. The header holds the receive status, the page where the following frame will start, and the byte count. That count includes the header itself and is stored low byte first.

The host owns a boundary page: the oldest page it has not yet consumed. The writer never enters that page. A frame that would need it, either for its own data or as the start page of the next frame, is dropped. The current page then stays where it was and an overwrite warning is raised. Three sticky interrupt flags (frame stored, frame stored with error, overwrite) are cleared by writing ones. Each flag can drive the interrupt line only when its mask bit is set.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the current page is 0, all interrupt flags and the interrupt line are low, the receive side is ready and no RAM write is issued.
- R2: A pulse on `cur_we_i` loads `cur_wdata_i` into the current page, visible on `cur_page_o` in the following cycle.
- R3: The bytes of a frame are written in arrival order to consecutive RAM addresses, starting at address {current page, 8'h04}, one write in the same cycle the byte is accepted.
- R4: After offset 255 of a page, writing continues at offset 0 of the next page. The page after `pg_stop_i - 1` is `pg_start_i`.
- R5: After the last byte, the header is written in exactly four consecutive cycles to offsets 0, 1, 2, 3 of the frame's first page, in the order status, next page, count low byte, count high byte. `rx_ready_o` is low during exactly those four cycles.
- R6: The header count is the number of frame bytes plus 4.
- R7: Header status byte: bit 0 set only when no error is flagged, bit 1 = CRC error (`rx_err_i[0]`), bit 2 = alignment error (`rx_err_i[1]`), bit 3 = FIFO overrun (`rx_err_i[2]`), bits 7:4 zero. Errors are sampled with the last byte.
- R8: After the header, the current page becomes the page following the last page the frame wrote, with the wrap of R4. This value is also the header's next-page byte.
- R9: If a frame needs to enter a new page equal to `bnd_pg_i`, no byte of the frame is written from then on and no header is written. The rest of the frame is consumed, the current page is unchanged, and flag bit 4 (overwrite) is set.
- R10: If the page that would follow a frame equals `bnd_pg_i`, that frame gets no header, the current page is unchanged, and flag bit 4 is set.
- R11: Flag bit 0 is set when a frame is committed with status bit 0 set, and flag bit 2 when it is committed with status bit 0 clear. Flags stay set until a 1 is written to the same position of `int_clr_i`. Other flag bits read 0.
- R12: `irq_o` is high exactly when some flag is set whose mask bit in `int_mask_i` (0x01, 0x04, 0x10) is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_last_i | input | 1 | Marks the last byte of a frame |
| rx_err_i | input | 3 | Frame error flags, sampled with the last byte |
| rx_ready_o | output | 1 | Byte accepted when high together with valid |
| pg_start_i | input | PAGE_W | First page of the ring |
| pg_stop_i | input | PAGE_W | Page limit of the ring (exclusive) |
| bnd_pg_i | input | PAGE_W | Host boundary page |
| cur_we_i | input | 1 | Load strobe for the current page |
| cur_wdata_i | input | PAGE_W | Current page load value |
| cur_page_o | output | PAGE_W | Current page |
| int_mask_i | input | 8 | Interrupt mask |
| int_clr_i | input | 8 | Write-one-to-clear strobes for the flags |
| int_stat_o | output | 8 | Interrupt flags |
| irq_o | output | 1 | Interrupt request |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | PAGE_W+8 | RAM byte address {page, offset} |
| mem_wdata_o | output | 8 | RAM write data |

## Verification
A wrong offset or page register shows up at once on `mem_addr_o`, in the same cycle the misplaced byte is accepted. The bench therefore compares every captured write against addresses computed from the ring bounds. Wrap and boundary mistakes only show when a frame crosses a page edge. Frames are therefore sized to end on offset 255, to spill across the limit page, and to hit the boundary both mid-frame and at the next-frame page. A wrong length count or status latch shows up four cycles after the last byte, in the header bytes. A wrong next-page value shows up twice: as a bad header byte, and as a bad `cur_page_o` when the next frame begins.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 16;

  // flag positions
  localparam int FLG_RX  = 0;
  localparam int FLG_ERR = 2;
  localparam int FLG_OVW = 4;
  localparam logic [BYTE_W-1:0] FLG_IMPL = 8'h15;

  // status byte positions
  localparam int STS_OK  = 0;
  localparam int STS_CRC = 1;
  localparam int STS_ALN = 2;
  localparam int STS_FOV = 3;

  typedef enum logic [2:0] {
    WR_IDLE, WR_DATA, WR_DROP, WR_H0, WR_H1, WR_H2, WR_H3
  } wr_state_e;

  function automatic logic [BYTE_W-1:0] mk_status(input logic [2:0] err);
    logic [BYTE_W-1:0] s;
    s          = '0;
    s[STS_OK]  = (err == 3'b000);
    s[STS_CRC] = err[0];
    s[STS_ALN] = err[1];
    s[STS_FOV] = err[2];
    return s;
  endfunction
endpackage

// File: rtl/ring_page_step.sv
module ring_page_step #(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [PAGE_W-1:0] pg_start_i,
  input  logic [PAGE_W-1:0] pg_stop_i,
  input  logic [PAGE_W-1:0] bnd_pg_i,
  output logic [PAGE_W-1:0] next_o,
  output logic              hit_o
);
  logic [PAGE_W-1:0] inc;

  always_comb begin
    inc    = page_i + 1'b1;
    next_o = (inc == pg_stop_i) ? pg_start_i : inc;
    hit_o  = (next_o == bnd_pg_i);
  end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import rx_ring_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int OFF_W     = 8,
  parameter int HDR_BYTES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rx_valid_i,
  input  logic [BYTE_W-1:0]       rx_data_i,
  input  logic                    rx_last_i,
  input  logic [2:0]              rx_err_i,
  output logic                    rx_ready_o,
  input  logic [PAGE_W-1:0]       pg_start_i,
  input  logic [PAGE_W-1:0]       pg_stop_i,
  input  logic [PAGE_W-1:0]       bnd_pg_i,
  input  logic                    cur_we_i,
  input  logic [PAGE_W-1:0]       cur_wdata_i,
  output logic [PAGE_W-1:0]       cur_page_o,
  output logic                    mem_we_o,
  output logic [PAGE_W+OFF_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0]       mem_wdata_o,
  output logic                    ev_rx_o,
  output logic                    ev_err_o,
  output logic                    ev_ovw_o
);
  localparam logic [OFF_W-1:0] DATA_OFF = OFF_W'(HDR_BYTES);
  localparam logic [CNT_W-1:0] HDR_CNT  = CNT_W'(HDR_BYTES);

  wr_state_e         state_q;
  logic [PAGE_W-1:0] cur_q, pg_q, hpg_q, nxt_q;
  logic [OFF_W-1:0]  off_q;
  logic [CNT_W-1:0]  len_q, cnt_q;
  logic [BYTE_W-1:0] sts_q;

  logic              in_idle, in_data, in_hdr, crossing, blocked, take, dwr, done;
  logic [PAGE_W-1:0] cross_pg, end_pg, wpage;
  logic              cross_hit, end_hit;
  logic [OFF_W-1:0]  woff, hoff;
  logic [CNT_W-1:0]  len_nx;
  logic [BYTE_W-1:0] hbyte;

  // page the data stream would enter after offset 255
  ring_page_step #(.PAGE_W(PAGE_W)) u_cross (
    .page_i(pg_q), .pg_start_i(pg_start_i), .pg_stop_i(pg_stop_i),
    .bnd_pg_i(bnd_pg_i), .next_o(cross_pg), .hit_o(cross_hit)
  );

  // page following the one this byte goes to (next-frame link)
  ring_page_step #(.PAGE_W(PAGE_W)) u_end (
    .page_i(wpage), .pg_start_i(pg_start_i), .pg_stop_i(pg_stop_i),
    .bnd_pg_i(bnd_pg_i), .next_o(end_pg), .hit_o(end_hit)
  );

  always_comb begin
    in_idle  = (state_q == WR_IDLE);
    in_data  = (state_q == WR_DATA);
    in_hdr   = (state_q == WR_H0) || (state_q == WR_H1) ||
               (state_q == WR_H2) || (state_q == WR_H3);
    done     = (state_q == WR_H3);
    crossing = in_data && (off_q == '0);
    wpage    = in_data ? (crossing ? cross_pg : pg_q) : cur_q;
    woff     = in_data ? off_q : DATA_OFF;
    blocked  = crossing && cross_hit;
    take     = rx_valid_i && (in_idle || in_data);
    dwr      = take && !blocked;
    len_nx   = in_idle ? CNT_W'(1) : len_q + 1'b1;
  end

  always_comb begin
    hoff  = '0;
    hbyte = sts_q;
    unique case (state_q)
      WR_H1:   begin hoff = OFF_W'(1); hbyte = nxt_q;        end
      WR_H2:   begin hoff = OFF_W'(2); hbyte = cnt_q[7:0];   end
      WR_H3:   begin hoff = OFF_W'(3); hbyte = cnt_q[15:8];  end
      default: begin hoff = '0;        hbyte = sts_q;        end
    endcase
  end

  always_comb begin
    rx_ready_o  = !in_hdr;
    mem_we_o    = in_hdr || dwr;
    mem_addr_o  = in_hdr ? {hpg_q, hoff} : {wpage, woff};
    mem_wdata_o = in_hdr ? hbyte : rx_data_i;
    cur_page_o  = cur_q;
    ev_rx_o     = done && sts_q[STS_OK];
    ev_err_o    = done && !sts_q[STS_OK];
    ev_ovw_o    = (take && blocked) || (dwr && rx_last_i && end_hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WR_IDLE;
      cur_q   <= '0;
      pg_q    <= '0;
      hpg_q   <= '0;
      nxt_q   <= '0;
      off_q   <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      sts_q   <= '0;
    end else begin
      unique case (state_q)
        WR_IDLE, WR_DATA: begin
          if (take) begin
            if (blocked) begin
              state_q <= rx_last_i ? WR_IDLE : WR_DROP;
            end else begin
              pg_q  <= wpage;
              off_q <= woff + 1'b1;
              len_q <= len_nx;
              if (in_idle) hpg_q <= cur_q;
              if (!rx_last_i) begin
                state_q <= WR_DATA;
              end else if (end_hit) begin
                state_q <= WR_IDLE;
              end else begin
                nxt_q   <= end_pg;
                cnt_q   <= len_nx + HDR_CNT;
                sts_q   <= mk_status(rx_err_i);
                state_q <= WR_H0;
              end
            end
          end
        end
        WR_DROP: if (rx_valid_i && rx_last_i) state_q <= WR_IDLE;
        WR_H0:   state_q <= WR_H1;
        WR_H1:   state_q <= WR_H2;
        WR_H2:   state_q <= WR_H3;
        WR_H3:   state_q <= WR_IDLE;
        default: state_q <= WR_IDLE;
      endcase

      if (done)          cur_q <= nxt_q;
      else if (cur_we_i) cur_q <= cur_wdata_i;
    end
  end
endmodule

// File: rtl/rx_irq_flags.sv
module rx_irq_flags
  import rx_ring_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_rx_i,
  input  logic              ev_err_i,
  input  logic              ev_ovw_i,
  input  logic [BYTE_W-1:0] clr_i,
  input  logic [BYTE_W-1:0] mask_i,
  output logic [BYTE_W-1:0] stat_o,
  output logic              irq_o
);
  logic [BYTE_W-1:0] set_v;

  always_comb begin
    set_v          = '0;
    set_v[FLG_RX]  = ev_rx_i;
    set_v[FLG_ERR] = ev_err_i;
    set_v[FLG_OVW] = ev_ovw_i;
  end

  for (genvar b = 0; b < BYTE_W; b++) begin : g_flag
    if (FLG_IMPL[b]) begin : g_impl
      logic f_q;
      // a new event wins over a clear in the same cycle
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       f_q <= 1'b0;
        else if (set_v[b]) f_q <= 1'b1;
        else if (clr_i[b]) f_q <= 1'b0;
      end
      assign stat_o[b] = f_q;
    end else begin : g_tie
      assign stat_o[b] = 1'b0;
    end
  end

  assign irq_o = |(stat_o & mask_i);
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rx_ring_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rx_valid_i,
  input  logic [7:0]              rx_data_i,
  input  logic                    rx_last_i,
  input  logic [2:0]              rx_err_i,
  output logic                    rx_ready_o,
  input  logic [PAGE_W-1:0]       pg_start_i,
  input  logic [PAGE_W-1:0]       pg_stop_i,
  input  logic [PAGE_W-1:0]       bnd_pg_i,
  input  logic                    cur_we_i,
  input  logic [PAGE_W-1:0]       cur_wdata_i,
  output logic [PAGE_W-1:0]       cur_page_o,
  input  logic [7:0]              int_mask_i,
  input  logic [7:0]              int_clr_i,
  output logic [7:0]              int_stat_o,
  output logic                    irq_o,
  output logic                    mem_we_o,
  output logic [PAGE_W+OFF_W-1:0] mem_addr_o,
  output logic [7:0]              mem_wdata_o
);
  localparam int HDR_BYTES = 4;

  logic ev_rx, ev_err, ev_ovw;

  rx_frame_fsm #(
    .PAGE_W(PAGE_W), .OFF_W(OFF_W), .HDR_BYTES(HDR_BYTES)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .rx_last_i(rx_last_i),
    .rx_err_i(rx_err_i), .rx_ready_o(rx_ready_o),
    .pg_start_i(pg_start_i), .pg_stop_i(pg_stop_i), .bnd_pg_i(bnd_pg_i),
    .cur_we_i(cur_we_i), .cur_wdata_i(cur_wdata_i), .cur_page_o(cur_page_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .ev_rx_o(ev_rx), .ev_err_o(ev_err), .ev_ovw_o(ev_ovw)
  );

  rx_irq_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ev_rx_i(ev_rx), .ev_err_i(ev_err), .ev_ovw_i(ev_ovw),
    .clr_i(int_clr_i), .mask_i(int_mask_i),
    .stat_o(int_stat_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int PAGE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_ready_i,
  input logic              mem_we_i,
  input logic              cur_we_i,
  input logic [PAGE_W-1:0] cur_page_i,
  input logic [7:0]        stat_i,
  input logic [7:0]        clr_i,
  input logic              irq_i
);
  // R5: header cycles always write
  p_hdr_writes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_ready_i |-> mem_we_i);

  // R5: stall lasts exactly four cycles
  p_hdr_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_ready_i) |=> !rx_ready_i ##1 !rx_ready_i ##1 !rx_ready_i ##1 rx_ready_i);

  // R8 / R9 / R10: current page moves only on commit or host load
  p_cur_move_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_page_i) |-> ($rose(rx_ready_i) || $past(cur_we_i)));

  // R11: flags are sticky until cleared
  p_flag_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(stat_i) & ~$past(clr_i)) & ~stat_i) == 8'h00));

  // R12: no request without a flag
  p_irq_src_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (stat_i != 8'h00));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_ready_i(rx_ready_o), .mem_we_i(mem_we_o),
  .cur_we_i(cur_we_i), .cur_page_i(cur_page_o), .stat_i(int_stat_o),
  .clr_i(int_clr_i), .irq_i(irq_o)
);

// File: tb/sim_rx_ring_writer.sv
`timescale 1ns/1ps
module sim_rx_ring_writer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_last_i = 1'b0;
  logic [2:0]  rx_err_i = '0;
  logic        rx_ready_o;
  logic [7:0]  pg_start_i = 8'h40;
  logic [7:0]  pg_stop_i = 8'h46;
  logic [7:0]  bnd_pg_i = 8'h3F;
  logic        cur_we_i = 1'b0;
  logic [7:0]  cur_wdata_i = '0;
  logic [7:0]  cur_page_o;
  logic [7:0]  int_mask_i = '0;
  logic [7:0]  int_clr_i = '0;
  logic [7:0]  int_stat_o;
  logic        irq_o;
  logic        mem_we_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  bit done = 1'b0;
  logic [7:0] mem_m [int];

  always #2 clk_i = ~clk_i;

  rx_ring_writer u0 (.*);

  always @(posedge clk_i) begin
    if (mem_we_o) begin
      mem_m[int'(mem_addr_o)] = mem_wdata_o;
      wr_cnt++;
    end
  end

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(i * 5 + seed * 3 + 1);
  endfunction

  function automatic logic [7:0] rd(input int addr);
    if (mem_m.exists(addr)) return mem_m[addr];
    return 8'hEE;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drives one frame; returns cycles with ready low after the last byte
  task automatic send_frame(input int len, input logic [2:0] err, input int seed,
                            output int lowc);
    for (int i = 0; i < len; i++) begin
      @(negedge clk_i);
      while (!rx_ready_o) @(negedge clk_i);
      rx_valid_i = 1'b1;
      rx_data_i  = pat(seed, i);
      rx_last_i  = (i == len - 1);
      rx_err_i   = (i == len - 1) ? err : 3'b000;
    end
    @(negedge clk_i);
    rx_valid_i = 1'b0;
    rx_last_i  = 1'b0;
    rx_err_i   = '0;
    lowc = 0;
    while (!rx_ready_o) begin
      lowc++;
      @(negedge clk_i);
    end
  endtask

  task automatic set_cur(input logic [7:0] p);
    @(negedge clk_i);
    cur_we_i = 1'b1; cur_wdata_i = p;
    @(negedge clk_i);
    cur_we_i = 1'b0;
    chk("R2 current page load", cur_page_o, p);
  endtask

  task automatic clr_flags(input logic [7:0] v);
    @(negedge clk_i);
    int_clr_i = v;
    @(negedge clk_i);
    int_clr_i = '0;
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R1 cur page", cur_page_o, 0);
    chk("R1 flags", int_stat_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 ready", rx_ready_o, 1);
    chk("R1 no write", mem_we_o, 0);
  endtask

  task automatic t_small;
    int lc;
    bit ok;
    set_cur(8'h40);
    clr_flags(8'hFF);
    int_mask_i = 8'h01;
    wr_cnt = 0;
    send_frame(10, 3'b000, 1, lc);
    ok = 1'b1;
    for (int i = 0; i < 10; i++)
      if (rd(16'h4004 + i) !== pat(1, i)) ok = 1'b0;
    chk("R3 data bytes in order", ok, 1);
    chk("R5 stall cycles", lc, 4);
    chk("R7 status intact", rd(16'h4000), 8'h01);
    chk("R8 next link", rd(16'h4001), 8'h41);
    chk("R6 count low", rd(16'h4002), 8'd14);
    chk("R6 count high", rd(16'h4003), 8'h00);
    chk("R5 write count", wr_cnt, 14);
    chk("R8 cur advance", cur_page_o, 8'h41);
    chk("R11 rx flag", int_stat_o, 8'h01);
    chk("R12 irq on rx", irq_o, 1);
  endtask

  task automatic t_err_and_mask;
    int lc;
    send_frame(3, 3'b101, 2, lc);
    chk("R7 status crc+fifo", rd(16'h4100), 8'h0A);
    chk("R6 count short frame", rd(16'h4102), 8'd7);
    chk("R8 cur after err frame", cur_page_o, 8'h42);
    chk("R11 err flag, rx sticky", int_stat_o, 8'h05);
    clr_flags(8'h01);
    chk("R11 w1c bit0 only", int_stat_o, 8'h04);
    chk("R12 masked out", irq_o, 0);
    @(negedge clk_i); int_mask_i = 8'h04;
    @(negedge clk_i);
    chk("R12 err unmasked", irq_o, 1);
    int_mask_i = 8'h10;
    @(negedge clk_i);
    chk("R12 ovw mask alone", irq_o, 0);
    send_frame(2, 3'b010, 3, lc);
    chk("R7 status align", rd(16'h4200), 8'h04);
  endtask

  task automatic t_exact_fill;
    int lc;
    set_cur(8'h42);
    clr_flags(8'hFF);
    wr_cnt = 0;
    send_frame(252, 3'b000, 4, lc);
    chk("R3 last byte at offset 255", rd(16'h42FF), pat(4, 251));
    chk("R6 count 256 low", rd(16'h4202), 8'h00);
    chk("R6 count 256 high", rd(16'h4203), 8'h01);
    chk("R8 link after full page", rd(16'h4201), 8'h43);
    chk("R4 no spill write", wr_cnt, 256);
    chk("R8 cur after full page", cur_page_o, 8'h43);
  endtask

  task automatic t_wrap;
    int lc;
    set_cur(8'h44);
    clr_flags(8'hFF);
    send_frame(518, 3'b000, 5, lc);
    chk("R4 page cross", rd(16'h4500), pat(5, 252));
    chk("R4 wrap to start", rd(16'h4000), pat(5, 508));
    chk("R4 wrap tail", rd(16'h4009), pat(5, 517));
    chk("R6 count 522 low", rd(16'h4402), 8'h0A);
    chk("R6 count 522 high", rd(16'h4403), 8'h02);
    chk("R8 link after wrap", rd(16'h4401), 8'h41);
    chk("R8 cur after wrap", cur_page_o, 8'h41);
  endtask

  task automatic t_ovw_cross;
    int lc;
    set_cur(8'h41);
    clr_flags(8'hFF);
    bnd_pg_i = 8'h43;
    mem_m[16'h4100] = 8'hC3;
    wr_cnt = 0;
    send_frame(600, 3'b000, 6, lc);
    chk("R9 writes stop before boundary", wr_cnt, 508);
    chk("R9 no header", rd(16'h4100), 8'hC3);
    chk("R9 no stall", lc, 0);
    chk("R9 cur kept", cur_page_o, 8'h41);
    chk("R9 ovw flag only", int_stat_o, 8'h10);
    chk("R12 ovw irq", irq_o, 1);
  endtask

  task automatic t_ovw_end;
    int lc;
    clr_flags(8'hFF);
    bnd_pg_i = 8'h42;
    mem_m[16'h4100] = 8'h5A;
    wr_cnt = 0;
    send_frame(20, 3'b000, 7, lc);
    chk("R10 data only", wr_cnt, 20);
    chk("R10 no header", rd(16'h4100), 8'h5A);
    chk("R10 cur kept", cur_page_o, 8'h41);
    chk("R10 ovw flag", int_stat_o, 8'h10);
    bnd_pg_i = 8'h3F;
    clr_flags(8'hFF);
    send_frame(5, 3'b000, 8, lc);
    chk("R8 recovery cur", cur_page_o, 8'h42);
    chk("R6 recovery count", rd(16'h4102), 8'd9);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_small();
    t_err_and_mask();
    t_exact_fill();
    t_wrap();
    t_ovw_cross();
    t_ovw_end();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule